// File: doc/BRIEF.md
# DDS Frequency and Phase Word Loader

This block sits behind the serial receiver of a direct digital synthesiser. It takes 16-bit command words that have already been deserialised, each marked by a one-cycle valid strobe. The two top bits of a word are an address. The remaining 14 bits are a payload. The payload goes to one of five registers: a control register, two 28-bit frequency tuning words, or two 12-bit phase offsets. The outputs always show the committed register contents, ready for the accumulator that follows.

A full 28-bit tuning word does not fit in one word. In paired mode it is sent as two writes, low half first. The target register changes only when the high half arrives, so the accumulator never sees a half-updated value. In split mode each 14-bit half is written on its own. A half-select bit in the control register picks which half.

Top module: `dds_word_loader`

## Requirements
- R1: A synchronous active-high reset clears the control word, both frequency words, both phase words and any pending low half.
- R2: A valid word with address bits 15:14 = 00 loads the control register with bits 15:14 = 00, bits 13:10 and 8:0 taken from the word, and bit 9 (reserved) forced to 0. The new value is visible one clock after the strobe.
- R3: When control bit 13 (paired mode) is 1, a frequency write that has no matching pending half is held as the low 14 bits. Both frequency outputs stay unchanged. Address 01 targets frequency word 0 and address 10 targets frequency word 1.
- R4: In paired mode, a second write to the same frequency address loads that word with {second payload, held low half} in one step, one clock after the strobe. The pending state is then cleared.
- R5: In paired mode, if the next frequency write targets the other frequency address, the held half is discarded. That write becomes a fresh first half for its own address.
- R6: When control bit 13 is 0, one frequency write changes only one half of the addressed word. Control bit 12 = 1 selects bits 27:14 and 0 selects bits 13:0. The other half is kept.
- R7: Control bit 12 has no effect while control bit 13 is 1.
- R8: Address 11 writes a phase word. Payload bit 13 = 0 selects phase word 0 and 1 selects phase word 1. Payload bits 11:0 are the value and payload bit 12 is ignored.
- R9: A control write that changes bit 13 drops any pending low half. Control writes that keep bit 13, and phase writes, leave a pending half in place.
- R10: A cycle without the valid strobe changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | One-cycle strobe marking a new command word |
| wr_word | input | 16 | Command word: address in 15:14, payload in 13:0 |
| ctrl_word | output | 16 | Committed control register |
| freq0 | output | 28 | Committed frequency word 0 |
| freq1 | output | 28 | Committed frequency word 1 |
| phase0 | output | 12 | Committed phase word 0 |
| phase1 | output | 12 | Committed phase word 1 |

## Verification
The assertions check on every cycle the local rules. A control write lands with its reserved bit cleared. A first paired half leaves both frequency words untouched and sets the pending state. A mode change drops the pending state. A split-mode write keeps the untouched half. Phase writes and idle cycles leave the frequency words alone. Whether a committed 28-bit word joins the correct two halves is shown only by the bench's scenarios. The same holds for restarts on a changed address and for a pending half surviving intervening control or phase writes, because those outcomes depend on words sent several cycles apart.

// File: rtl/dds_wl_pkg.sv
package dds_wl_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL = 2'b00,
    ADR_FRQ0 = 2'b01,
    ADR_FRQ1 = 2'b10,
    ADR_PHS  = 2'b11
  } adr_e;

  localparam int HALF_W   = 14;
  localparam int PHASE_W  = 12;
  localparam int PAIR_BIT = 13;
  localparam int HSEL_BIT = 12;
  localparam int RSV_BIT  = 9;
  localparam int PSEL_BIT = 13;
endpackage

// File: rtl/dds_wl_decode.sv
module dds_wl_decode #(
  parameter int HALF_W = dds_wl_pkg::HALF_W,
  localparam int WORD_W = HALF_W + 2
) (
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  output logic              hit_ctrl,
  output logic              hit_freq,
  output logic              hit_phase,
  output logic              freq_idx,
  output logic [HALF_W-1:0] payload
);
  import dds_wl_pkg::*;

  adr_e adr;

  always_comb begin
    adr       = adr_e'(wr_word[WORD_W-1 -: 2]);
    payload   = wr_word[HALF_W-1:0];
    hit_ctrl  = wr_valid && (adr == ADR_CTRL);
    hit_freq  = wr_valid && ((adr == ADR_FRQ0) || (adr == ADR_FRQ1));
    hit_phase = wr_valid && (adr == ADR_PHS);
    freq_idx  = (adr == ADR_FRQ1);
  end
endmodule

// File: rtl/dds_wl_freq.sv
module dds_wl_freq #(
  parameter int HALF_W = dds_wl_pkg::HALF_W,
  parameter int N_REG  = 2,
  localparam int FREQ_W = 2 * HALF_W,
  localparam int IDX_W  = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic [IDX_W-1:0]            idx,
  input  logic [HALF_W-1:0]           payload,
  input  logic                        pair_mode,
  input  logic                        hsel,
  input  logic                        clr_pend,
  output logic [N_REG-1:0][FREQ_W-1:0] freq_q,
  output logic                        pend_q,
  output logic [IDX_W-1:0]            pend_idx_q,
  output logic                        ev_stage,
  output logic                        ev_full,
  output logic                        ev_half
);
  logic [HALF_W-1:0] lsb_q;

  function automatic logic [FREQ_W-1:0] join_halves(
    input logic [HALF_W-1:0] hi, input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [FREQ_W-1:0] put_half(
    input logic [FREQ_W-1:0] old, input logic [HALF_W-1:0] val, input logic upper);
    return upper ? {val, old[HALF_W-1:0]} : {old[FREQ_W-1:HALF_W], val};
  endfunction

  always_comb begin
    ev_full  = wr && pair_mode && pend_q && (pend_idx_q == idx);
    ev_stage = wr && pair_mode && !ev_full;
    ev_half  = wr && !pair_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      lsb_q      <= '0;
    end else if (clr_pend) begin
      pend_q <= 1'b0;
    end else if (ev_stage) begin
      pend_q     <= 1'b1;
      pend_idx_q <= idx;
      lsb_q      <= payload;
    end else if (ev_full) begin
      pend_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        freq_q[g] <= '0;
      else if (ev_full && (idx == IDX_W'(g)))
        freq_q[g] <= join_halves(payload, lsb_q);
      else if (ev_half && (idx == IDX_W'(g)))
        freq_q[g] <= put_half(freq_q[g], payload, hsel);
    end
  end
endmodule

// File: rtl/dds_wl_phase.sv
module dds_wl_phase #(
  parameter int HALF_W  = dds_wl_pkg::HALF_W,
  parameter int PHASE_W = dds_wl_pkg::PHASE_W,
  parameter int SEL_BIT = dds_wl_pkg::PSEL_BIT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [HALF_W-1:0]      payload,
  output logic [1:0][PHASE_W-1:0] phase_q
);
  for (genvar g = 0; g < 2; g++) begin : g_ph
    always_ff @(posedge clk) begin
      if (rst)
        phase_q[g] <= '0;
      else if (wr && (payload[SEL_BIT] == 1'(g)))
        phase_q[g] <= payload[PHASE_W-1:0];
    end
  end
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
  parameter int HALF_W  = dds_wl_pkg::HALF_W,
  parameter int PHASE_W = dds_wl_pkg::PHASE_W,
  localparam int WORD_W = HALF_W + 2,
  localparam int FREQ_W = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [WORD_W-1:0]  wr_word,
  output logic [WORD_W-1:0]  ctrl_word,
  output logic [FREQ_W-1:0]  freq0,
  output logic [FREQ_W-1:0]  freq1,
  output logic [PHASE_W-1:0] phase0,
  output logic [PHASE_W-1:0] phase1
);
  import dds_wl_pkg::*;

  logic              hit_ctrl, hit_freq, hit_phase, freq_idx;
  logic [HALF_W-1:0] payload;
  logic [WORD_W-1:0] ctrl_q;
  logic              clr_pend, pend_q, pend_idx_q;
  logic              ev_stage, ev_full, ev_half;
  logic [1:0][FREQ_W-1:0]  freq_q;
  logic [1:0][PHASE_W-1:0] phase_q;

  function automatic logic [WORD_W-1:0] scrub_ctrl(input logic [HALF_W-1:0] p);
    logic [HALF_W-1:0] m;
    m = p;
    m[RSV_BIT] = 1'b0;
    return {2'b00, m};
  endfunction

  dds_wl_decode #(.HALF_W(HALF_W)) u_dec (
    .wr_valid (wr_valid),
    .wr_word  (wr_word),
    .hit_ctrl (hit_ctrl),
    .hit_freq (hit_freq),
    .hit_phase(hit_phase),
    .freq_idx (freq_idx),
    .payload  (payload)
  );

  assign clr_pend = hit_ctrl && (payload[PAIR_BIT] != ctrl_q[PAIR_BIT]);

  always_ff @(posedge clk) begin
    if (rst)           ctrl_q <= '0;
    else if (hit_ctrl) ctrl_q <= scrub_ctrl(payload);
  end

  dds_wl_freq #(.HALF_W(HALF_W), .N_REG(2)) u_frq (
    .clk       (clk),
    .rst       (rst),
    .wr        (hit_freq),
    .idx       (freq_idx),
    .payload   (payload),
    .pair_mode (ctrl_q[PAIR_BIT]),
    .hsel      (ctrl_q[HSEL_BIT]),
    .clr_pend  (clr_pend),
    .freq_q    (freq_q),
    .pend_q    (pend_q),
    .pend_idx_q(pend_idx_q),
    .ev_stage  (ev_stage),
    .ev_full   (ev_full),
    .ev_half   (ev_half)
  );

  dds_wl_phase #(.HALF_W(HALF_W), .PHASE_W(PHASE_W), .SEL_BIT(PSEL_BIT)) u_phs (
    .clk    (clk),
    .rst    (rst),
    .wr     (hit_phase),
    .payload(payload),
    .phase_q(phase_q)
  );

  assign ctrl_word = ctrl_q;
  assign freq0     = freq_q[0];
  assign freq1     = freq_q[1];
  assign phase0    = phase_q[0];
  assign phase1    = phase_q[1];
endmodule

// File: rtl/dds_word_loader_chk.sv
module dds_word_loader_chk #(
  parameter int HALF_W  = 14,
  parameter int PHASE_W = 12,
  localparam int WORD_W = HALF_W + 2,
  localparam int FREQ_W = 2 * HALF_W
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_valid,
  input logic [WORD_W-1:0]  wr_word,
  input logic [WORD_W-1:0]  ctrl_word,
  input logic [FREQ_W-1:0]  freq0,
  input logic [FREQ_W-1:0]  freq1,
  input logic [PHASE_W-1:0] phase0,
  input logic [PHASE_W-1:0] phase1,
  input logic               hit_ctrl,
  input logic               hit_freq,
  input logic               hit_phase,
  input logic               clr_pend,
  input logic               pend_q
);
  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    hit_ctrl |=> (ctrl_word[WORD_W-1 -: 2] == 2'b00) && (ctrl_word[9] == 1'b0)
                 && (ctrl_word[13:10] == $past(wr_word[13:10]))
                 && (ctrl_word[8:0] == $past(wr_word[8:0])));

  a_r3_first_half_holds: assert property (@(posedge clk) disable iff (rst)
    (hit_freq && ctrl_word[13] && !pend_q) |=> pend_q && $stable(freq0) && $stable(freq1));

  a_r6_split_keeps_low: assert property (@(posedge clk) disable iff (rst)
    (hit_freq && !ctrl_word[13] && ctrl_word[12] && (wr_word[WORD_W-1 -: 2] == 2'b01))
      |=> (freq0[HALF_W-1:0] == $past(freq0[HALF_W-1:0]))
          && (freq0[FREQ_W-1:HALF_W] == $past(wr_word[HALF_W-1:0])) && $stable(freq1));

  a_r8_phase_spares_freq: assert property (@(posedge clk) disable iff (rst)
    hit_phase |=> $stable(freq0) && $stable(freq1) && $stable(ctrl_word));

  a_r9_mode_change_drops: assert property (@(posedge clk) disable iff (rst)
    clr_pend |=> !pend_q);

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(ctrl_word) && $stable(freq0) && $stable(freq1)
                  && $stable(phase0) && $stable(phase1) && $stable(pend_q));
endmodule

bind dds_word_loader dds_word_loader_chk #(.HALF_W(HALF_W), .PHASE_W(PHASE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_word  (wr_word),
  .ctrl_word(ctrl_word),
  .freq0    (freq0),
  .freq1    (freq1),
  .phase0   (phase0),
  .phase1   (phase1),
  .hit_ctrl (hit_ctrl),
  .hit_freq (hit_freq),
  .hit_phase(hit_phase),
  .clr_pend (clr_pend),
  .pend_q   (pend_q)
);

// File: tb/sim_dds_word_loader.sv
module sim_dds_word_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_word = '0;
  logic [15:0] ctrl_word;
  logic [27:0] freq0, freq1;
  logic [11:0] phase0, phase1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench reference state
  logic [15:0] m_ctrl;
  logic [27:0] m_f0, m_f1;
  logic [11:0] m_p0, m_p1;
  logic        m_pend, m_pidx;
  logic [13:0] m_lsb;

  always #5 clk = ~clk;

  dds_word_loader u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
    .ctrl_word(ctrl_word), .freq0(freq0), .freq1(freq1),
    .phase0(phase0), .phase1(phase1)
  );

  function automatic logic [27:0] half_upd(input logic [27:0] old, input logic [13:0] v,
                                           input logic top);
    logic [27:0] r;
    r = old;
    if (top) r[27:14] = v; else r[13:0] = v;
    return r;
  endfunction

  function automatic string tag_of(input logic [15:0] w);
    case (w[15:14])
      2'b00:   return "R2";
      2'b11:   return "R8";
      default: return m_ctrl[13] ? "R4" : "R6";
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = '0; m_f0 = '0; m_f1 = '0; m_p0 = '0; m_p1 = '0;
    m_pend = 1'b0; m_pidx = 1'b0; m_lsb = '0;
  endtask

  task automatic model_step(input logic [15:0] w);
    logic [13:0] p;
    logic        ix;
    p  = w[13:0];
    ix = (w[15:14] == 2'b10);
    case (w[15:14])
      2'b00: begin
        if (p[13] != m_ctrl[13]) m_pend = 1'b0;
        m_ctrl = {2'b00, p[13:10], 1'b0, p[8:0]};
      end
      2'b11: begin
        if (p[13]) m_p1 = p[11:0]; else m_p0 = p[11:0];
      end
      default: begin
        if (!m_ctrl[13]) begin
          if (ix) m_f1 = half_upd(m_f1, p, m_ctrl[12]);
          else    m_f0 = half_upd(m_f0, p, m_ctrl[12]);
        end else if (m_pend && m_pidx == ix) begin
          if (ix) m_f1 = {p, m_lsb}; else m_f0 = {p, m_lsb};
          m_pend = 1'b0;
        end else begin
          m_pend = 1'b1; m_pidx = ix; m_lsb = p;
        end
      end
    endcase
  endtask

  task automatic chk(input string tag, input string what, input logic [27:0] act,
                     input logic [27:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "ctrl",   {12'h0, ctrl_word}, {12'h0, m_ctrl});
    chk(tag, "freq0",  freq0, m_f0);
    chk(tag, "freq1",  freq1, m_f1);
    chk(tag, "phase0", {16'h0, phase0}, {16'h0, m_p0});
    chk(tag, "phase1", {16'h0, phase1}, {16'h0, m_p1});
  endtask

  // drive at negedge, register at posedge, compare at the following negedge
  task automatic send(input logic [15:0] w, input string tag);
    wr_valid = 1'b1;
    wr_word  = w;
    @(posedge clk);
    model_step(w);
    @(negedge clk);
    wr_valid = 1'b0;
    chk_all(tag);
  endtask

  task automatic idle(input logic [15:0] w, input string tag);
    wr_valid = 1'b0;
    wr_word  = w;
    @(negedge clk);
    chk_all(tag);
  endtask

  initial begin
    logic [27:0] keep0;
    logic [15:0] w;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_all("R1");

    // R2: reserved bit 9 forced low
    send(16'h2200, "R2");
    chk("R2", "rsv", {27'h0, ctrl_word[9]}, 28'h0);
    // R7: paired mode with half-select set
    send(16'h3000, "R7");
    send(16'h4000 | 16'h1234, "R3");
    chk("R3", "freq0 held", freq0, 28'h0);
    send(16'h4000 | 16'h0ABC, "R4");
    chk("R7", "freq0 joined", freq0, {14'h0ABC, 14'h1234});
    // R5: restart on the other address
    keep0 = freq0;
    send(16'h4000 | 16'h0111, "R5");
    send(16'h8000 | 16'h0222, "R5");
    send(16'h8000 | 16'h0333, "R5");
    chk("R5", "freq1", freq1, {14'h0333, 14'h0222});
    chk("R5", "freq0 kept", freq0, keep0);
    // R9: same-mode control and phase writes keep the pending half
    send(16'h4000 | 16'h0015, "R9");
    send(16'h2000, "R9");
    send(16'hC000 | 16'h0055, "R9");
    send(16'h4000 | 16'h0016, "R9");
    chk("R9", "freq0 commit", freq0, {14'h0016, 14'h0015});
    // R9: mode change drops the pending half
    keep0 = freq0;
    send(16'h4000 | 16'h0017, "R9");
    send(16'h0000, "R9");
    send(16'h2000, "R9");
    send(16'h4000 | 16'h0018, "R9");
    chk("R9", "freq0 no commit", freq0, keep0);
    // R6: split mode halves
    send(16'h1000, "R6");
    send(16'h4000 | 16'h3FFF, "R6");
    chk("R6", "freq0 top", {14'h0, freq0[27:14]}, 28'h3FFF);
    send(16'h0000, "R6");
    send(16'h8000 | 16'h0005, "R6");
    chk("R6", "freq1 low", {14'h0, freq1[13:0]}, 28'h5);
    // R8: phase select and ignored bit 12
    send(16'hC000 | 16'h1ABC, "R8");
    chk("R8", "phase0", {16'h0, phase0}, 28'hABC);
    send(16'hE000 | 16'h0123, "R8");
    chk("R8", "phase1", {16'h0, phase1}, 28'h123);
    // R10: no strobe
    idle(16'h4FFF, "R10");
    idle(16'h0000, "R10");

    // constrained random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 800; i++) begin
      int k;
      k = int'($urandom % 16);
      w = 16'($urandom);
      if (k < 2)       w[15:14] = 2'b00;
      else if (k < 12) w[15:14] = (k[0]) ? 2'b01 : 2'b10;
      else if (k < 14) w[15:14] = 2'b11;
      if (k == 15) idle(w, "R10");
      else         send(w, tag_of(w));
    end

    // R1: reset mid-sequence
    wr_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk_all("R1");
    send(16'h4000 | 16'h0001, "R1");
    chk("R1", "split after reset", freq0, 28'h1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule